// File: doc/BRIEF.md
# Multi-Source Reset Distributor

This block collects every reset request on the chip and turns them into four active-low reset domains. The domains are cold, global, sleep and port-configuration. The requests come from five places: a power-on indication qualified by a regulator-ready flag, an external active-low reset pin, a port-pattern request, a watchdog timeout and a bus-error request. A software sleep bit is a sixth, separate request.

Each domain asserts asynchronously as soon as its request rises. It is released synchronously by a small sequencer built as a state machine. The sequencer waits for a two-stage release synchronizer, then counts a hold window, and only then lets the output go high. The sequencer has three states:

- HELD: the domain is in reset.
- COUNT: the hold window is running.
- RUN: the domain is released.

Its transitions are:

- any state to HELD on a request;
- HELD to COUNT once the synchronizer has released;
- COUNT to COUNT while the counter is not zero;
- COUNT to RUN when the counter reaches zero.

A three-bit control register holds the watchdog-reset enable, the port-configuration enable and the sleep bit. A three-bit sticky cause register records which warm sources have fired. Both registers are cleared only by the cold domain, so a warm reset leaves them as they were.

Top module: `rstdist_ctrl`

## Requirements
- R1: While `por_active_i` is 1 or `reg_ready_i` is 0, the cold, global and port-configuration outputs are 0. Dropping `por_active_i` alone does not release them while the regulator is not ready.
- R2: A 0 on `ext_rst_n_i` asserts the cold output after two clock edges of synchronization. The warm sources and the sleep bit never assert the cold output.
- R3: The global output is 0 whenever the cold output is 0 or any warm source is active. The warm sources are the synchronized port request, the bus-error request, and the watchdog request gated by the enable. Direct warm requests assert it without waiting for a clock.
- R4: With control bit 0 (watchdog enable) at 0, `wdt_req_i` has no effect: the global output stays 1 and cause bit 1 stays 0.
- R5: The sleep output is 0 exactly while control bit 2 (sleep) is 1, plus the release window. The sleep bit asserts neither cold nor global, and no warm source asserts the sleep output.
- R6: With control bit 1 (port-configuration enable) at 1, the port-configuration output follows the global output. With it at 0, only cold sources assert it.
- R7: Release timing. An output returns to 1 at the 7th rising edge after its request falls: 2 synchronizer stages, then a 4-cycle hold, then one registered step. The minimum low time is therefore at least 4 cycles.
- R8: `ctrl_we_i` writes `ctrl_wdata_i` into the control register, which reads back on `ctrl_o`. The cold output clears it to 0, and a warm reset leaves it unchanged.
- R9: Cause bit 0 is the port request, bit 1 the enabled watchdog and bit 2 the bus error. A bit is set at a clock edge where its source is active, stays set, and is cleared by the cold output.
- R10: A 1 in `cause_clr_i` clears the matching cause bit at the next edge. The other bits are untouched, and a source active in the same cycle wins over the clear.
- R11: The port request passes two flops before use. Global falls at the second edge after it rises, and it is released 9 edges after it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_active_i | input | 1 | Power-on indication, high while powering up |
| reg_ready_i | input | 1 | Internal regulator has started |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| port_req_i | input | 1 | Port-pattern reset request, asynchronous |
| wdt_req_i | input | 1 | Watchdog timeout request |
| buserr_req_i | input | 1 | Bus-error reset request |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 3 | Control write data: bit0 watchdog enable, bit1 port-config enable, bit2 sleep |
| cause_clr_i | input | 3 | Write-one-to-clear strobes for the cause bits |
| ctrl_o | output | 3 | Control register contents |
| cause_o | output | 3 | Sticky cause: bit0 port, bit1 watchdog, bit2 bus error |
| rst_cold_n_o | output | 1 | Cold reset, active low |
| rst_global_n_o | output | 1 | Global reset, active low |
| rst_sleep_n_o | output | 1 | Sleep reset, active low |
| rst_pconf_n_o | output | 1 | Port-configuration reset, active low |

## Verification
The bench sweeps all 32 combinations of the two enables and the three warm sources. For each one it checks global, port-configuration and cause against values computed from the dependency rules. A design that left the watchdog unmasked, or tied port-configuration to global regardless of the enable, would miss here.

Release is timed edge by edge for direct sources, synchronized sources, the pin and the sleep bit. An off-by-one in the synchronizer or the hold counter shows up as a release one cycle early or late.

Pin and warm resets are checked against the control and cause registers. A register wired to the global domain would lose its contents on a warm reset. Another case drives a clear and a live source in the same cycle, which catches a design that lets the clear win.

// File: rtl/rstdist_pkg.sv
package rstdist_pkg;

    localparam int DOM_N   = 4;
    localparam int CAUSE_W = 3;
    localparam int CTRL_W  = 3;

    localparam int DOM_COLD   = 0;
    localparam int DOM_GLOBAL = 1;
    localparam int DOM_SLEEP  = 2;
    localparam int DOM_PCONF  = 3;

    localparam int CAUSE_PORT = 0;
    localparam int CAUSE_WDT  = 1;
    localparam int CAUSE_BUS  = 2;

    typedef enum logic [1:0] {
        REL_HELD  = 2'd0,
        REL_COUNT = 2'd1,
        REL_RUN   = 2'd2
    } rel_state_t;

    typedef struct packed {
        logic sleep;
        logic en_pconf;
        logic en_wdt;
    } ctrl_t;

endpackage

// File: rtl/rstdist_sync.sv
module rstdist_sync #(
    parameter int STAGES = 2,
    parameter bit INIT   = 1'b0
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            chain_q <= {STAGES{INIT}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstdist_release.sv
module rstdist_release
    import rstdist_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 4,
    parameter bit RUN_AT_INIT = 1'b0
) (
    input  logic clk_i,
    input  logic init_i,
    input  logic req_i,
    output logic rst_n_o
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYCLES - 1);

    logic [SYNC_STAGES-1:0] rel_sync_q;
    logic                   sync_done;
    rel_state_t             state_q;
    rel_state_t             state_d;
    logic [CNT_W-1:0]       cnt_q;
    logic [CNT_W-1:0]       cnt_d;
    logic                   rst_n_q;

    // release synchronizer: cleared asynchronously, fills with ones
    always_ff @(posedge clk_i or posedge req_i or posedge init_i) begin
        if (req_i) begin
            rel_sync_q <= '0;
        end else if (init_i) begin
            rel_sync_q <= {SYNC_STAGES{RUN_AT_INIT}};
        end else begin
            rel_sync_q <= {rel_sync_q[SYNC_STAGES-2:0], 1'b1};
        end
    end

    assign sync_done = rel_sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk_i or posedge req_i or posedge init_i) begin
        if (req_i) begin
            state_q <= REL_HELD;
            cnt_q   <= CNT_LOAD;
        end else if (init_i) begin
            state_q <= RUN_AT_INIT ? REL_RUN : REL_HELD;
            cnt_q   <= CNT_LOAD;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            REL_HELD: begin
                cnt_d = CNT_LOAD;
                if (sync_done) begin
                    state_d = REL_COUNT;
                end
            end
            REL_COUNT: begin
                if (cnt_q == '0) begin
                    state_d = REL_RUN;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            REL_RUN: begin
                state_d = REL_RUN;
            end
            default: begin
                state_d = REL_HELD;
                cnt_d   = CNT_LOAD;
            end
        endcase
    end

    // registered output, asserted asynchronously
    always_ff @(posedge clk_i or posedge req_i or posedge init_i) begin
        if (req_i) begin
            rst_n_q <= 1'b0;
        end else if (init_i) begin
            rst_n_q <= RUN_AT_INIT;
        end else begin
            rst_n_q <= (state_d == REL_RUN);
        end
    end

    assign rst_n_o = rst_n_q;

endmodule

// File: rtl/rstdist_regs.sv
module rstdist_regs
    import rstdist_pkg::*;
(
    input  logic               clk_i,
    input  logic               cold_rst_n_i,
    input  logic               we_i,
    input  ctrl_t              wdata_i,
    input  logic [CAUSE_W-1:0] clr_i,
    input  logic [CAUSE_W-1:0] src_i,
    output ctrl_t              ctrl_o,
    output logic [CAUSE_W-1:0] cause_o
);

    ctrl_t              ctrl_q;
    logic [CAUSE_W-1:0] cause_q;

    always_ff @(posedge clk_i or negedge cold_rst_n_i) begin
        if (!cold_rst_n_i) begin
            ctrl_q <= '0;
        end else if (we_i) begin
            ctrl_q <= wdata_i;
        end
    end

    for (genvar i = 0; i < CAUSE_W; i++) begin : g_cause
        always_ff @(posedge clk_i or negedge cold_rst_n_i) begin
            if (!cold_rst_n_i) begin
                cause_q[i] <= 1'b0;
            end else if (src_i[i]) begin
                cause_q[i] <= 1'b1;
            end else if (clr_i[i]) begin
                cause_q[i] <= 1'b0;
            end
        end
    end

    assign ctrl_o  = ctrl_q;
    assign cause_o = cause_q;

endmodule

// File: rtl/rstdist_ctrl.sv
module rstdist_ctrl
    import rstdist_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 4
) (
    input  logic         clk_i,
    input  logic         por_active_i,
    input  logic         reg_ready_i,
    input  logic         ext_rst_n_i,
    input  logic         port_req_i,
    input  logic         wdt_req_i,
    input  logic         buserr_req_i,
    input  logic         ctrl_we_i,
    input  logic [2:0]   ctrl_wdata_i,
    input  logic [2:0]   cause_clr_i,
    output logic [2:0]   ctrl_o,
    output logic [2:0]   cause_o,
    output logic         rst_cold_n_o,
    output logic         rst_global_n_o,
    output logic         rst_sleep_n_o,
    output logic         rst_pconf_n_o
);

    logic               por_req;
    logic               pin_n_s;
    logic               port_s;
    logic               wdt_hit;
    logic               warm_req;
    logic               cold_req;
    logic               glob_req;
    ctrl_t              ctrl;
    logic [CAUSE_W-1:0] cause_src;
    logic [DOM_N-1:0]   dom_req;
    logic [DOM_N-1:0]   dom_rst_n;

    // power-on held until the regulator reports ready
    assign por_req = por_active_i | ~reg_ready_i;

    rstdist_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_pin_sync (
        .clk_i  (clk_i),
        .arst_i (por_req),
        .d_i    (ext_rst_n_i),
        .q_o    (pin_n_s)
    );

    rstdist_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_port_sync (
        .clk_i  (clk_i),
        .arst_i (por_req),
        .d_i    (port_req_i),
        .q_o    (port_s)
    );

    assign wdt_hit  = wdt_req_i & ctrl.en_wdt;
    assign warm_req = port_s | wdt_hit | buserr_req_i;
    assign cold_req = por_req | ~pin_n_s;
    assign glob_req = cold_req | warm_req;

    assign dom_req[DOM_COLD]   = cold_req;
    assign dom_req[DOM_GLOBAL] = glob_req;
    assign dom_req[DOM_SLEEP]  = ctrl.sleep;
    assign dom_req[DOM_PCONF]  = ctrl.en_pconf ? glob_req : cold_req;

    for (genvar d = 0; d < DOM_N; d++) begin : g_dom
        rstdist_release #(
            .SYNC_STAGES (SYNC_STAGES),
            .HOLD_CYCLES (HOLD_CYCLES),
            .RUN_AT_INIT (d == DOM_SLEEP)
        ) u_rel (
            .clk_i   (clk_i),
            .init_i  (por_req),
            .req_i   (dom_req[d]),
            .rst_n_o (dom_rst_n[d])
        );
    end

    assign cause_src[CAUSE_PORT] = port_s;
    assign cause_src[CAUSE_WDT]  = wdt_hit;
    assign cause_src[CAUSE_BUS]  = buserr_req_i;

    rstdist_regs u_regs (
        .clk_i        (clk_i),
        .cold_rst_n_i (dom_rst_n[DOM_COLD]),
        .we_i         (ctrl_we_i),
        .wdata_i      (ctrl_t'(ctrl_wdata_i)),
        .clr_i        (cause_clr_i),
        .src_i        (cause_src),
        .ctrl_o       (ctrl),
        .cause_o      (cause_o)
    );

    assign ctrl_o         = ctrl;
    assign rst_cold_n_o   = dom_rst_n[DOM_COLD];
    assign rst_global_n_o = dom_rst_n[DOM_GLOBAL];
    assign rst_sleep_n_o  = dom_rst_n[DOM_SLEEP];
    assign rst_pconf_n_o  = dom_rst_n[DOM_PCONF];

endmodule

// File: rtl/rstdist_ctrl_checker.sv
module rstdist_ctrl_checker #(
    parameter int HOLD_CYCLES = 4
) (
    input logic       clk_i,
    input logic       por_active_i,
    input logic       reg_ready_i,
    input logic       wdt_req_i,
    input logic [2:0] cause_clr_i,
    input logic [2:0] ctrl_o,
    input logic [2:0] cause_o,
    input logic       rst_cold_n_o,
    input logic       rst_global_n_o,
    input logic       rst_sleep_n_o,
    input logic       rst_pconf_n_o
);

    logic       pwr_busy;
    logic [7:0] low_cnt;

    assign pwr_busy = por_active_i | ~reg_ready_i;

    always_ff @(posedge clk_i) begin
        if (pwr_busy || rst_global_n_o) begin
            low_cnt <= '0;
        end else if (low_cnt != 8'hFF) begin
            low_cnt <= low_cnt + 8'd1;
        end
    end

    AST_COLD_IN_GLOBAL: assert property (@(posedge clk_i) disable iff (pwr_busy)
        !rst_cold_n_o |-> !rst_global_n_o); // R3

    AST_COLD_IN_PCONF: assert property (@(posedge clk_i) disable iff (pwr_busy)
        !rst_cold_n_o |-> !rst_pconf_n_o); // R6

    AST_SLEEP_FROM_BIT: assert property (@(posedge clk_i) disable iff (pwr_busy)
        ctrl_o[2] |-> !rst_sleep_n_o); // R5

    AST_WDT_MASKED: assert property (@(posedge clk_i) disable iff (pwr_busy)
        $rose(cause_o[1]) |-> $past(ctrl_o[0] && wdt_req_i)); // R4

    AST_CAUSE_STICKY_BUS: assert property (@(posedge clk_i) disable iff (pwr_busy)
        (cause_o[2] && !cause_clr_i[2]) |=> (cause_o[2] || !rst_cold_n_o)); // R9

    AST_CAUSE_STICKY_PORT: assert property (@(posedge clk_i) disable iff (pwr_busy)
        (cause_o[0] && !cause_clr_i[0]) |=> (cause_o[0] || !rst_cold_n_o)); // R9

    AST_GLOBAL_HOLD: assert property (@(posedge clk_i) disable iff (pwr_busy)
        $rose(rst_global_n_o) |-> (low_cnt >= 8'(HOLD_CYCLES))); // R7

endmodule

bind rstdist_ctrl rstdist_ctrl_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk_i          (clk_i),
    .por_active_i   (por_active_i),
    .reg_ready_i    (reg_ready_i),
    .wdt_req_i      (wdt_req_i),
    .cause_clr_i    (cause_clr_i),
    .ctrl_o         (ctrl_o),
    .cause_o        (cause_o),
    .rst_cold_n_o   (rst_cold_n_o),
    .rst_global_n_o (rst_global_n_o),
    .rst_sleep_n_o  (rst_sleep_n_o),
    .rst_pconf_n_o  (rst_pconf_n_o)
);

// File: tb/rstdist_ctrl_bench.sv
module rstdist_ctrl_bench;

    logic       clk = 1'b0;
    logic       por_active, reg_ready, ext_rst_n, port_req, wdt_req, buserr_req;
    logic       ctrl_we;
    logic [2:0] ctrl_wdata, cause_clr;
    logic [2:0] ctrl_o, cause_o;
    logic       cold_n, glob_n, sleep_n, pconf_n;
    int         errs = 0;
    int         checks = 0;

    always #10 clk = ~clk;

    rstdist_ctrl u_rstdist_ctrl (
        .clk_i          (clk),
        .por_active_i   (por_active),
        .reg_ready_i    (reg_ready),
        .ext_rst_n_i    (ext_rst_n),
        .port_req_i     (port_req),
        .wdt_req_i      (wdt_req),
        .buserr_req_i   (buserr_req),
        .ctrl_we_i      (ctrl_we),
        .ctrl_wdata_i   (ctrl_wdata),
        .cause_clr_i    (cause_clr),
        .ctrl_o         (ctrl_o),
        .cause_o        (cause_o),
        .rst_cold_n_o   (cold_n),
        .rst_global_n_o (glob_n),
        .rst_sleep_n_o  (sleep_n),
        .rst_pconf_n_o  (pconf_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic nedge(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [2:0] v);
        ctrl_wdata = v;
        ctrl_we    = 1'b1;
        nedge(1);
        ctrl_we    = 1'b0;
    endtask

    task automatic clr_cause(input logic [2:0] v);
        cause_clr = v;
        nedge(1);
        cause_clr = 3'b000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        por_active = 1'b1; reg_ready = 1'b0; ext_rst_n = 1'b1;
        port_req = 1'b0; wdt_req = 1'b0; buserr_req = 1'b0;
        ctrl_we = 1'b0; ctrl_wdata = 3'b000; cause_clr = 3'b000;
        nedge(4);
        // R1 reset state
        check("R1 por cold", 32'(cold_n), 32'd0);
        check("R1 por global", 32'(glob_n), 32'd0);
        check("R1 por pconf", 32'(pconf_n), 32'd0);
        check("R5 sleep idle at power-on", 32'(sleep_n), 32'd1);
        check("R8 ctrl reset", 32'(ctrl_o), 32'd0);
        check("R9 cause reset", 32'(cause_o), 32'd0);
        por_active = 1'b0;
        nedge(5);
        check("R1 held by regulator", 32'(cold_n), 32'd0);
        reg_ready = 1'b1;
        for (int k = 1; k <= 7; k++) begin
            nedge(1);
            check("R7 cold release after power-on", 32'(cold_n), 32'(k >= 7));
        end
        check("R7 global release", 32'(glob_n), 32'd1);
        check("R6 pconf release", 32'(pconf_n), 32'd1);

        // R8 write / readback
        wr_ctrl(3'b011);
        check("R8 ctrl readback", 32'(ctrl_o), 32'd3);
        wr_ctrl(3'b000);

        // R7 direct source timing
        buserr_req = 1'b1;
        #1;
        check("R3 bus error asserts global at once", 32'(glob_n), 32'd0);
        nedge(1);
        buserr_req = 1'b0;
        for (int k = 1; k <= 7; k++) begin
            nedge(1);
            check("R7 global release from bus error", 32'(glob_n), 32'(k >= 7));
        end
        check("R6 pconf unaffected warm", 32'(pconf_n), 32'd1);
        check("R9 bus cause", 32'(cause_o), 32'd4);
        clr_cause(3'b111);

        // R11 synchronized port request
        port_req = 1'b1;
        nedge(1);
        check("R11 port not yet", 32'(glob_n), 32'd1);
        nedge(1);
        check("R11 port asserts at 2nd edge", 32'(glob_n), 32'd0);
        port_req = 1'b0;
        for (int k = 1; k <= 9; k++) begin
            nedge(1);
            check("R11 port release", 32'(glob_n), 32'(k >= 9));
        end
        clr_cause(3'b111);

        // sweep: enables x warm sources
        for (int c = 0; c < 32; c++) begin
            logic ew, ep, p, w, b, eg;
            ew = c[0]; ep = c[1]; p = c[2]; w = c[3]; b = c[4];
            eg = p | b | (w & ew);
            wr_ctrl({1'b0, ep, ew});
            port_req = p; wdt_req = w; buserr_req = b;
            nedge(3);
            check("R3 R4 sweep global", 32'(glob_n), 32'(!eg));
            check("R6 sweep pconf", 32'(pconf_n), 32'(!(ep & eg)));
            check("R2 sweep cold", 32'(cold_n), 32'd1);
            check("R5 sweep sleep", 32'(sleep_n), 32'd1);
            port_req = 1'b0; wdt_req = 1'b0; buserr_req = 1'b0;
            nedge(12);
            check("R7 sweep all released", 32'({cold_n, glob_n, sleep_n, pconf_n}), 32'hF);
            check("R8 sweep ctrl kept over warm reset", 32'(ctrl_o), 32'({1'b0, ep, ew}));
            check("R9 sweep cause", 32'(cause_o), 32'({b, w & ew, p}));
            clr_cause(3'b111);
            check("R10 sweep clear", 32'(cause_o), 32'd0);
        end
        wr_ctrl(3'b000);

        // R10 set wins over clear, and selective clear
        buserr_req = 1'b1;
        port_req   = 1'b1;
        nedge(3);
        cause_clr = 3'b100;
        nedge(1);
        cause_clr = 3'b000;
        check("R10 set beats clear", 32'(cause_o[2]), 32'd1);
        buserr_req = 1'b0;
        port_req   = 1'b0;
        nedge(12);
        clr_cause(3'b001);
        check("R10 selective clear", 32'(cause_o), 32'd4);
        clr_cause(3'b100);
        check("R10 cleared", 32'(cause_o), 32'd0);

        // R5 sleep bit
        wr_ctrl(3'b100);
        check("R5 sleep asserted", 32'(sleep_n), 32'd0);
        check("R5 sleep leaves cold/global/pconf", 32'({cold_n, glob_n, pconf_n}), 32'h7);
        check("R8 sleep bit readback", 32'(ctrl_o), 32'd4);
        wr_ctrl(3'b000);
        check("R7 sleep still held", 32'(sleep_n), 32'd0);
        for (int k = 2; k <= 8; k++) begin
            nedge(1);
            check("R7 sleep release", 32'(sleep_n), 32'(k >= 8));
        end

        // R2 pin cold reset clears registers
        wr_ctrl(3'b011);
        buserr_req = 1'b1;
        nedge(1);
        buserr_req = 1'b0;
        nedge(10);
        check("R9 cause before pin", 32'(cause_o), 32'd4);
        ext_rst_n = 1'b0;
        nedge(1);
        check("R2 pin not yet", 32'(cold_n), 32'd1);
        nedge(1);
        check("R2 pin cold", 32'(cold_n), 32'd0);
        check("R2 pin global", 32'(glob_n), 32'd0);
        check("R6 pin pconf", 32'(pconf_n), 32'd0);
        check("R8 ctrl cleared by cold", 32'(ctrl_o), 32'd0);
        check("R9 cause cleared by cold", 32'(cause_o), 32'd0);
        ext_rst_n = 1'b1;
        for (int k = 1; k <= 9; k++) begin
            nedge(1);
            check("R2 pin release", 32'(cold_n), 32'(k >= 9));
        end

        // R4 watchdog ignored after cold cleared the enable
        wdt_req = 1'b1;
        #1;
        check("R4 wdt masked immediate", 32'(glob_n), 32'd1);
        nedge(2);
        check("R4 wdt masked global", 32'(glob_n), 32'd1);
        check("R4 wdt masked cause", 32'(cause_o), 32'd0);
        wdt_req = 1'b0;
        nedge(2);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule